// File: doc/BRIEF.md
# Directory MSI Coherence Controller

This block keeps the coherence records for one bank of an inclusive shared last-level cache that serves a small group of private caches. The bank holds a direct-mapped set of directory lines. Each line stores a tag, a two-bit stable state (Invalid, Shared or Modified) and an exact per-core sharer vector. Cores send read misses, write misses and replacement notices over a valid/ready request port. The controller works out the new state and sends invalidations, forwards or inclusion recalls to the cores that really hold the line. It counts their acknowledgements, then answers the requester with a data grant or a notice acknowledgement.

Private caches report every replacement, clean or dirty, so the sharer vector is never larger than the true set of holders. Invalidations and recalls therefore reach only real copies. A line can be needed for a different tag while it still has holders. In that case the controller recalls every private copy, frees the line once all of them have answered, and then serves the new request. While messages are outstanding, the whole bank is busy and the request port is held not-ready.

A combinational lookup port returns the state and sharer vector of any address. This is the view that the bank's miss logic would consult.

Top module: `coh_dir_ctrl`

## Requirements
- R1: After reset every line reads Invalid (state code 0) with an empty sharer vector, req_ready is high and msg_valid is low.
- R2: A write miss (request code 1) from core k to an Invalid line makes it Modified (state code 2) with only sharer bit k set (bit k stands for core k). The only message is a DATA grant to core k.
- R3: A read miss (request code 0) to an Invalid or Shared line leaves it Shared (state code 1) with the requester's bit ORed into the vector. The only message is a DATA grant.
- R4: A read miss from core j to a line Modified by core i, with i not equal to j, sends one FWD to core i. After its ack the line is Shared with bits i and j set. A read or write miss from the current owner sends no control message and leaves the line Modified with only its bit set.
- R5: A write miss from core j to a line Modified by core i, with i not equal to j, sends exactly one FWD to core i. After its ack the line stays Modified with only bit j set.
- R6: A write miss from core j to a Shared line sends one INV to each other core whose bit is set, and none when j is the only sharer. After all acks the line is Modified with only bit j set.
- R7: A replacement notice, clean (code 2) or dirty (code 3), from core k clears bit k. The line becomes Invalid when the vector empties, and the reply is an ACK. A notice for a tag that is not present, or from a core whose bit is clear, changes nothing. The state is Invalid exactly when the vector is empty.
- R8: A read or write miss to an index whose line holds another tag with holders sends a RECALL to every holder. Once all have acked, the old address reads Invalid and the request is served as if the line were Invalid.
- R9: A line whose holders have all left is reused by a different tag at once, with no RECALL.
- R10: From the cycle a request is accepted until its reply is handed off, req_ready stays low.
- R11: The reply is presented only after every addressed core has acked. Acks from cores with no pending message are ignored.
- R12: Message type codes are INV=0, FWD=1, RECALL=2, DATA=3, ACK=4. The line index is the low IDX_W address bits and the tag is the remaining bits.
- R13: While msg_valid is high and msg_ready is low, the message (core, type, address) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_core | input | CID_W | Requesting core |
| req_kind | input | 2 | 0 read miss, 1 write miss, 2 clean replacement, 3 dirty replacement |
| req_addr | input | ADDR_W | Block address |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_core | output | CID_W | Destination core |
| msg_kind | output | 3 | Message type code (R12) |
| msg_addr | output | ADDR_W | Block address the message concerns |
| ack_valid | input | 1 | One acknowledgement this cycle |
| ack_core | input | CID_W | Core sending the acknowledgement |
| probe_addr | input | ADDR_W | Lookup address |
| probe_state | output | 2 | State of probe_addr (0 when not present) |
| probe_sharers | output | NCORE | Sharer vector of probe_addr (0 when not present) |

## Verification
A request taken at one edge is decided at the next edge. Its first control message is presented in the following cycle, and further messages follow one per cycle while msg_ready is high. Once the last expected ack has been counted, the controller needs one more edge before the reply appears. The directory update becomes visible on the lookup port right after the edge that hands the reply off. The bench drives and samples on falling edges. It collects messages as they appear, returns acks one per cycle, and reads the lookup port only after the reply handoff edge. This keeps every check after the register that produces its result. A sweep over all ordered owner pairs covers ownership migration, with each expected FWD mask computed from the pair indices.

// File: rtl/coh_pkg.sv
package coh_pkg;
  // line states
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_M = 2'd2;
  // request kinds
  localparam logic [1:0] RK_READ  = 2'd0;
  localparam logic [1:0] RK_WRITE = 2'd1;
  localparam logic [1:0] RK_EVC   = 2'd2;
  localparam logic [1:0] RK_EVD   = 2'd3;
  // outgoing message kinds
  localparam logic [2:0] MK_INV    = 3'd0;
  localparam logic [2:0] MK_FWD    = 3'd1;
  localparam logic [2:0] MK_RECALL = 3'd2;
  localparam logic [2:0] MK_DATA   = 3'd3;
  localparam logic [2:0] MK_ACK    = 3'd4;

  typedef enum logic [2:0] {
    FS_IDLE, FS_DECIDE, FS_SEND, FS_WAIT, FS_REPLY
  } fsm_e;
endpackage

// File: rtl/coh_rst_sync.sv
module coh_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_n_sync <= stage_q;
    end
  end
endmodule

// File: rtl/coh_dir_array.sv
module coh_dir_array #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6,
  parameter int NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  output logic [1:0]       rd_st,
  output logic [NCORE-1:0] rd_shr,
  input  logic [IDX_W-1:0] pr_idx,
  output logic [TAG_W-1:0] pr_tag,
  output logic [1:0]       pr_st,
  output logic [NCORE-1:0] pr_shr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [1:0]       wr_st,
  input  logic [NCORE-1:0] wr_shr
);
  logic [TAG_W-1:0] tag_q [LINES];
  logic [1:0]       st_q  [LINES];
  logic [NCORE-1:0] shr_q [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic line_en;
    assign line_en = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_q[g] <= '0;
        st_q[g]  <= '0;
        shr_q[g] <= '0;
      end else if (line_en) begin
        tag_q[g] <= wr_tag;
        st_q[g]  <= wr_st;
        shr_q[g] <= wr_shr;
      end
    end
  end

  assign rd_tag = tag_q[rd_idx];
  assign rd_st  = st_q[rd_idx];
  assign rd_shr = shr_q[rd_idx];
  assign pr_tag = tag_q[pr_idx];
  assign pr_st  = st_q[pr_idx];
  assign pr_shr = shr_q[pr_idx];
endmodule

// File: rtl/coh_lsb_pick.sv
module coh_lsb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  mask,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (mask[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/coh_ack_counter.sv
module coh_ack_counter #(
  parameter int NCORE = 4,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NCORE-1:0] load_mask,
  input  logic             dec,
  output logic [CNT_W-1:0] left
);
  logic [CNT_W-1:0] pc;
  logic [CNT_W-1:0] left_d;
  logic             cnt_en;

  always_comb begin
    pc = '0;
    for (int i = 0; i < NCORE; i++) pc = pc + CNT_W'(load_mask[i]);
  end

  assign cnt_en = load | dec;
  assign left_d = load ? pc : (left - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left <= '0;
    else if (cnt_en) left <= left_d;
  end
endmodule

// File: rtl/coh_dir_ctrl.sv
module coh_dir_ctrl
  import coh_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2,
  localparam int CID_W = (NCORE > 1) ? $clog2(NCORE) : 1,
  localparam int TAG_W = ADDR_W - IDX_W,
  localparam int LINES = 1 << IDX_W,
  localparam int CNT_W = $clog2(NCORE + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CID_W-1:0]  req_core,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [CID_W-1:0]  msg_core,
  output logic [2:0]        msg_kind,
  output logic [ADDR_W-1:0] msg_addr,
  input  logic              ack_valid,
  input  logic [CID_W-1:0]  ack_core,
  input  logic [ADDR_W-1:0] probe_addr,
  output logic [1:0]        probe_state,
  output logic [NCORE-1:0]  probe_sharers
);
  logic rst_n_i;
  coh_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  fsm_e              fsm_q, fsm_d;
  logic [CID_W-1:0]  rq_core_q;
  logic [1:0]        rq_kind_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [NCORE-1:0]  send_q, send_d, pend_q, pend_d;
  logic [2:0]        skind_q;
  logic              victim_q, pwr_q;
  logic [1:0]        pst_q;
  logic [NCORE-1:0]  pshr_q;
  logic [ADDR_W-1:0] oaddr_q;

  logic [IDX_W-1:0]  rq_idx;
  logic [TAG_W-1:0]  rq_tag;
  logic [NCORE-1:0]  req_bit;
  logic              is_evict;

  logic [TAG_W-1:0]  rd_tag, pr_tag, wr_tag;
  logic [1:0]        rd_st, pr_st, wr_st;
  logic [NCORE-1:0]  rd_shr, pr_shr, wr_shr;
  logic              wr_en;

  logic [CID_W-1:0]  pick_idx;
  logic              ack_take, cnt_load;
  logic [CNT_W-1:0]  ack_left;

  // decision outputs
  logic [NCORE-1:0]  dc_targets, dc_shr, eff_shr;
  logic [2:0]        dc_kind;
  logic [1:0]        dc_st, eff_st;
  logic              dc_victim, dc_wr, hit;

  assign rq_idx   = rq_addr_q[IDX_W-1:0];
  assign rq_tag   = rq_addr_q[ADDR_W-1:IDX_W];
  assign req_bit  = NCORE'(1) << rq_core_q;
  assign is_evict = rq_kind_q[1];

  coh_dir_array #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .NCORE(NCORE)) u_dir (
    .clk(clk), .rst_n(rst_n_i),
    .rd_idx(rq_idx), .rd_tag(rd_tag), .rd_st(rd_st), .rd_shr(rd_shr),
    .pr_idx(probe_addr[IDX_W-1:0]), .pr_tag(pr_tag), .pr_st(pr_st), .pr_shr(pr_shr),
    .wr_en(wr_en), .wr_idx(rq_idx), .wr_tag(wr_tag), .wr_st(wr_st), .wr_shr(wr_shr)
  );

  coh_lsb_pick #(.N(NCORE), .IW(CID_W)) u_pick (.mask(send_q), .idx(pick_idx));

  assign ack_take = ack_valid && pend_q[ack_core] &&
                    ((fsm_q == FS_SEND) || (fsm_q == FS_WAIT));

  coh_ack_counter #(.NCORE(NCORE), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n_i), .load(cnt_load), .load_mask(dc_targets),
    .dec(ack_take), .left(ack_left)
  );

  // lookup port
  always_comb begin
    if ((pr_tag == probe_addr[ADDR_W-1:IDX_W]) && (pr_st != ST_I)) begin
      probe_state   = pr_st;
      probe_sharers = pr_shr;
    end else begin
      probe_state   = ST_I;
      probe_sharers = '0;
    end
  end

  // coherence decision for the latched request
  always_comb begin
    hit        = (rd_tag == rq_tag) && (rd_st != ST_I);
    eff_st     = hit ? rd_st : ST_I;
    eff_shr    = hit ? rd_shr : '0;
    dc_targets = '0;
    dc_kind    = MK_INV;
    dc_victim  = 1'b0;
    dc_st      = eff_st;
    dc_shr     = eff_shr;
    dc_wr      = 1'b1;
    if (is_evict) begin
      if (hit && ((rd_shr & req_bit) != '0)) begin
        dc_shr = rd_shr & ~req_bit;
        dc_st  = (dc_shr == '0) ? ST_I : ST_S;
      end else begin
        dc_wr = 1'b0;
      end
    end else if (!hit && (rd_st != ST_I)) begin
      dc_targets = rd_shr;
      dc_kind    = MK_RECALL;
      dc_victim  = 1'b1;
      dc_st      = ST_I;
      dc_shr     = '0;
    end else if (rq_kind_q == RK_READ) begin
      case (eff_st)
        ST_M: begin
          if (eff_shr != req_bit) begin
            dc_targets = eff_shr;
            dc_kind    = MK_FWD;
            dc_st      = ST_S;
            dc_shr     = eff_shr | req_bit;
          end
        end
        default: begin
          dc_st  = ST_S;
          dc_shr = eff_shr | req_bit;
        end
      endcase
    end else begin
      case (eff_st)
        ST_M: begin
          if (eff_shr != req_bit) begin
            dc_targets = eff_shr;
            dc_kind    = MK_FWD;
          end
        end
        ST_S: begin
          dc_targets = eff_shr & ~req_bit;
          dc_kind    = MK_INV;
        end
        default: ;
      endcase
      dc_st  = ST_M;
      dc_shr = req_bit;
    end
  end

  // next state and outputs
  always_comb begin
    fsm_d     = fsm_q;
    send_d    = send_q;
    pend_d    = pend_q;
    req_ready = 1'b0;
    msg_valid = 1'b0;
    msg_core  = pick_idx;
    msg_kind  = skind_q;
    msg_addr  = oaddr_q;
    wr_en     = 1'b0;
    wr_tag    = rq_tag;
    wr_st     = pst_q;
    wr_shr    = pshr_q;
    cnt_load  = 1'b0;
    if (ack_take) pend_d = pend_q & ~(NCORE'(1) << ack_core);
    case (fsm_q)
      FS_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) fsm_d = FS_DECIDE;
      end
      FS_DECIDE: begin
        send_d   = dc_targets;
        pend_d   = dc_targets;
        cnt_load = 1'b1;
        if (dc_targets != '0) fsm_d = FS_SEND;
        else if (dc_victim)   fsm_d = FS_WAIT;
        else                  fsm_d = FS_REPLY;
      end
      FS_SEND: begin
        msg_valid = 1'b1;
        if (msg_ready) begin
          send_d = send_q & ~(NCORE'(1) << pick_idx);
          if (send_d == '0) fsm_d = FS_WAIT;
        end
      end
      FS_WAIT: begin
        if (ack_left == '0) begin
          if (victim_q) begin
            wr_en  = 1'b1;
            wr_tag = rd_tag;
            wr_st  = ST_I;
            wr_shr = '0;
            fsm_d  = FS_DECIDE;
          end else begin
            fsm_d = FS_REPLY;
          end
        end
      end
      FS_REPLY: begin
        msg_valid = 1'b1;
        msg_core  = rq_core_q;
        msg_kind  = is_evict ? MK_ACK : MK_DATA;
        msg_addr  = rq_addr_q;
        if (msg_ready) begin
          wr_en = pwr_q;
          fsm_d = FS_IDLE;
        end
      end
      default: fsm_d = FS_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      fsm_q     <= FS_IDLE;
      rq_core_q <= '0;
      rq_kind_q <= '0;
      rq_addr_q <= '0;
      send_q    <= '0;
      pend_q    <= '0;
      skind_q   <= '0;
      victim_q  <= 1'b0;
      pwr_q     <= 1'b0;
      pst_q     <= '0;
      pshr_q    <= '0;
      oaddr_q   <= '0;
    end else begin
      fsm_q  <= fsm_d;
      send_q <= send_d;
      pend_q <= pend_d;
      if ((fsm_q == FS_IDLE) && req_valid) begin
        rq_core_q <= req_core;
        rq_kind_q <= req_kind;
        rq_addr_q <= req_addr;
      end
      if (fsm_q == FS_DECIDE) begin
        skind_q  <= dc_kind;
        victim_q <= dc_victim;
        pwr_q    <= dc_wr;
        pst_q    <= dc_st;
        pshr_q   <= dc_shr;
        oaddr_q  <= dc_victim ? {rd_tag, rq_idx} : rq_addr_q;
      end
    end
  end
endmodule

// File: rtl/coh_dir_ctrl_chk.sv
module coh_dir_ctrl_chk #(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 8,
  parameter int CID_W  = 2,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              msg_valid,
  input logic              msg_ready,
  input logic [CID_W-1:0]  msg_core,
  input logic [2:0]        msg_kind,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [1:0]        probe_state,
  input logic [NCORE-1:0]  probe_sharers,
  input logic [CNT_W-1:0]  ack_left
);
  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_msg_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_core) &&
                                   $stable(msg_kind) && $stable(msg_addr)));

  assert_legal_kind_R12: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_kind <= 3'd4));

  assert_reply_after_acks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && (msg_kind >= 3'd3)) |-> (ack_left == '0));

  assert_empty_iff_invalid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((probe_state == 2'd0) == (probe_sharers == '0)));

  assert_owner_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_state == 2'd2) |-> $onehot(probe_sharers));
endmodule

bind coh_dir_ctrl coh_dir_ctrl_chk #(
  .NCORE(NCORE), .ADDR_W(ADDR_W), .CID_W(CID_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_core(msg_core),
  .msg_kind(msg_kind), .msg_addr(msg_addr), .probe_state(probe_state),
  .probe_sharers(probe_sharers), .ack_left(ack_left)
);

// File: tb/coh_dir_ctrl_tb_top.sv
module coh_dir_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_ready;
  logic [1:0] req_core, req_kind;
  logic [7:0] req_addr;
  logic       msg_valid, msg_ready;
  logic [1:0] msg_core;
  logic [2:0] msg_kind;
  logic [7:0] msg_addr;
  logic       ack_valid;
  logic [1:0] ack_core;
  logic [7:0] probe_addr;
  logic [1:0] probe_state;
  logic [3:0] probe_sharers;

  int checks = 0;
  int errors = 0;
  int rec_inv, rec_fwd, rec_rcl, rep_kind, rep_core;
  bit early, busy_bad, stall_bad, timed_out;
  int st, shr;

  always #5 clk = ~clk;

  coh_dir_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_kind(req_kind), .req_addr(req_addr),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_core(msg_core),
    .msg_kind(msg_kind), .msg_addr(msg_addr), .ack_valid(ack_valid),
    .ack_core(ack_core), .probe_addr(probe_addr), .probe_state(probe_state),
    .probe_sharers(probe_sharers)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic look(input logic [7:0] a);
    probe_addr = a;
    #1;
    st  = int'(probe_state);
    shr = int'(probe_sharers);
  endtask

  // issue one request at a falling edge and serve its messages until the reply
  task automatic do_req(input int core, input int kind, input logic [7:0] addr,
                        input int hold, input int stall);
    int need = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit seen = 1'b0;
    logic [1:0] s_core = '0;
    logic [2:0] s_kind = '0;
    rec_inv = 0; rec_fwd = 0; rec_rcl = 0; rep_kind = -1; rep_core = -1;
    early = 0; busy_bad = 0; stall_bad = 0; timed_out = 0;
    req_valid = 1'b1;
    req_core  = 2'(core);
    req_kind  = 2'(kind);
    req_addr  = addr;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && cyc < 100) begin
      cyc++;
      if (req_ready) busy_bad = 1'b1;
      ack_valid = 1'b0;
      if (msg_valid) begin
        if (stall > 0) begin
          msg_ready = 1'b0;
          if (seen && (msg_core != s_core || msg_kind != s_kind)) stall_bad = 1'b1;
          s_core = msg_core; s_kind = msg_kind; seen = 1'b1;
          stall--;
        end else begin
          msg_ready = 1'b1;
          case (msg_kind)
            3'd0: rec_inv |= (1 << msg_core);
            3'd1: rec_fwd |= (1 << msg_core);
            3'd2: rec_rcl |= (1 << msg_core);
            default: begin
              rep_kind = int'(msg_kind);
              rep_core = int'(msg_core);
              done = 1'b1;
              if (hold > 0) early = 1'b1;
            end
          endcase
          if (msg_kind < 3'd3) need |= (1 << msg_core);
        end
      end
      if (!done) begin
        if (hold > 0) begin
          hold--;
          ack_valid = 1'b1;
          ack_core  = 2'(core);
        end else if (need != 0) begin
          for (int i = 3; i >= 0; i--) if (need[i]) ack_core = 2'(i);
          ack_valid = 1'b1;
          need &= ~(1 << ack_core);
        end
      end
      @(negedge clk);
    end
    ack_valid = 1'b0;
    msg_ready = 1'b1;
    if (!done) timed_out = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_core = '0; req_kind = '0; req_addr = '0;
    msg_ready = 1'b1; ack_valid = 1'b0; ack_core = '0; probe_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 msg_valid", int'(msg_valid), 0);
    for (int a = 0; a < 4; a++) begin
      look(8'(a * 5));
      chk("R1 state", st, 0);
      chk("R1 sharers", shr, 0);
    end

    // R2 core0 writes A
    do_req(0, 1, 8'h10, 0, 0);
    chk("R2 reply kind DATA (R12)", rep_kind, 3);
    chk("R2 reply core", rep_core, 0);
    chk("R2 no ctrl msgs", rec_inv | rec_fwd | rec_rcl, 0);
    chk("R2 timeout", int'(timed_out), 0);
    look(8'h10); chk("R2 A state", st, 2); chk("R2 A sharers", shr, 4'b0001);

    // R3 cores 1 and 2 read B
    do_req(1, 0, 8'h21, 0, 0);
    chk("R3 reply kind", rep_kind, 3);
    do_req(2, 0, 8'h21, 0, 0);
    chk("R3 no ctrl msgs", rec_inv | rec_fwd | rec_rcl, 0);
    look(8'h21); chk("R3 B state", st, 1); chk("R3 B sharers", shr, 4'b0110);

    // R5 core3 writes A owned by core0
    do_req(3, 1, 8'h10, 0, 0);
    chk("R5 fwd mask", rec_fwd, 4'b0001);
    chk("R5 no inv", rec_inv, 0);
    look(8'h10); chk("R5 A state", st, 2); chk("R5 A sharers", shr, 4'b1000);

    // R6 core1 writes B shared by 1 and 2
    do_req(1, 1, 8'h21, 0, 0);
    chk("R6 inv mask", rec_inv, 4'b0100);
    chk("R6 reply core", rep_core, 1);
    look(8'h21); chk("R6 B state", st, 2); chk("R6 B sharers", shr, 4'b0010);

    // R8 core2 reads C at B's index: recall core1
    do_req(2, 0, 8'h41, 0, 0);
    chk("R8 recall mask", rec_rcl, 4'b0010);
    look(8'h21); chk("R8 B gone state", st, 0); chk("R8 B gone sharers", shr, 0);
    look(8'h41); chk("R8 C state", st, 1); chk("R8 C sharers", shr, 4'b0100);

    // R7 clean replacement, then R9 reuse without recall
    do_req(2, 2, 8'h41, 0, 0);
    chk("R7 reply kind ACK (R12)", rep_kind, 4);
    look(8'h41); chk("R7 C state", st, 0); chk("R7 C sharers", shr, 0);
    do_req(0, 0, 8'h21, 0, 0);
    chk("R9 no recall", rec_rcl, 0);
    look(8'h21); chk("R9 B state", st, 1); chk("R9 B sharers", shr, 4'b0001);

    // R4 core1 reads A owned by core3
    do_req(1, 0, 8'h10, 0, 0);
    chk("R4 fwd mask", rec_fwd, 4'b1000);
    look(8'h10); chk("R4 A state", st, 1); chk("R4 A sharers", shr, 4'b1010);

    // R11 and R10: stray acks must not release the write
    do_req(0, 0, 8'h12, 0, 0);
    do_req(3, 0, 8'h12, 0, 0);
    do_req(1, 1, 8'h12, 8, 0);
    chk("R11 premature reply", int'(early), 0);
    chk("R11 inv mask", rec_inv, 4'b1001);
    chk("R10 busy while pending", int'(busy_bad), 0);
    look(8'h12); chk("R6 D state", st, 2); chk("R6 D sharers", shr, 4'b0010);

    // R7 dirty notice from non-holder is ignored, from holder clears
    do_req(0, 3, 8'h12, 0, 0);
    chk("R7 ack to non-holder", rep_kind, 4);
    look(8'h12); chk("R7 D unchanged state", st, 2); chk("R7 D unchanged sharers", shr, 4'b0010);
    do_req(1, 3, 8'h12, 0, 0);
    look(8'h12); chk("R7 D freed state", st, 0); chk("R7 D freed sharers", shr, 0);

    // R13 reply held under back-pressure; R4 owner rereads
    do_req(2, 1, 8'h13, 0, 3);
    chk("R13 message held", int'(stall_bad), 0);
    chk("R13 reply kind", rep_kind, 3);
    do_req(2, 0, 8'h13, 0, 0);
    chk("R4 owner reread no msgs", rec_inv | rec_fwd | rec_rcl, 0);
    look(8'h13); chk("R4 E state", st, 2); chk("R4 E sharers", shr, 4'b0100);
    do_req(2, 2, 8'h13, 0, 0);

    // R5/R2 sweep over all owner pairs on one address
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        do_req(i, 1, 8'h33, 0, 0);
        chk($sformatf("R2 sweep first write i=%0d", i), rec_inv | rec_fwd | rec_rcl, 0);
        look(8'h33);
        chk($sformatf("R2 sweep sharers i=%0d", i), shr, 1 << i);
        do_req(j, 1, 8'h33, 0, 0);
        chk($sformatf("R5 sweep fwd i=%0d j=%0d", i, j), rec_fwd, (i != j) ? (1 << i) : 0);
        look(8'h33);
        chk($sformatf("R5 sweep state i=%0d j=%0d", i, j), st, 2);
        chk($sformatf("R5 sweep sharers i=%0d j=%0d", i, j), shr, 1 << j);
        do_req(j, 2, 8'h33, 0, 0);
        look(8'h33);
        chk($sformatf("R7 sweep freed j=%0d", j), st, 0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule